// File: doc/BRIEF.md
# Interrupt Rate Throttle Timer

This block spaces out the interrupt pulses of a single interrupt vector. A set of pending cause bits is filtered through a select mask. When at least one selected cause is pending and the throttle counter stands at zero, the block emits an interrupt pulse. In the same cycle it reloads the counter from a programmable interval. The counter then steps down once per timing tick until it reaches zero, and the next pulse cannot come before that.

The interval and the live counter share one 32-bit register, which software reads and writes through a simple port with a separate write strobe for each half. Software can therefore retune the throttle mid-flight by overwriting the running count. An interval of zero turns the throttle off, so every selected pending cause is signalled at once. The timing tick comes from an internal prescaler that divides the core clock by a parameter, chosen so that one tick lasts 256 ns.

Top module: `irq_throttle_timer`

## Requirements
- R1: After reset, `irq_pulse` is low and `reg_rd_data` reads zero, both interval and counter.
- R2: `reg_rd_data[15:0]` returns the interval and `reg_rd_data[31:16]` returns the live counter. `reg_wr_lo` loads the interval from `reg_wr_data[15:0]` and `reg_wr_hi` loads the counter from `reg_wr_data[31:16]`. Each strobe takes effect on its own, and the new value is visible in the following cycle.
- R3: With an interval of zero, a selected pending cause produces a pulse in the cycle after every cycle in which it is pending.
- R4: In a cycle that fires, the counter is reloaded with the interval value held in that cycle, unless a counter write happens in the same cycle.
- R5: The internal tick occurs once every `TICK_DIV` clock cycles, the first one `TICK_DIV` cycles after reset. The counter decreases by one on each tick, holds at zero without wrapping, and otherwise keeps its value.
- R6: A cycle fires when the counter is zero and `cause_pend & cause_sel` is non-zero. `irq_pulse` is high in exactly the cycle after each firing cycle and low otherwise.
- R7: A pending cause whose select bit is zero never causes a pulse and does not disturb the counter.
- R8: A counter write replaces the count in the next cycle, and it takes precedence over both the reload and the decrement.
- R9: Because the counter resets to zero, the first selected pending cause after reset is signalled without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_pend | input | NCAUSE | Pending interrupt cause bits |
| cause_sel | input | NCAUSE | Select mask; only the causes selected here can fire |
| reg_wr_lo | input | 1 | Write strobe for the interval half |
| reg_wr_hi | input | 1 | Write strobe for the counter half |
| reg_wr_data | input | 32 | Write data; low half is the interval, high half is the counter |
| reg_rd_data | output | 32 | Read data: {counter, interval} |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
A corrupted counter shows up on the high half of the read port in the very next cycle. It also moves the next interrupt pulse earlier or later by whole tick periods, so a skipped or doubled decrement displaces a pulse by `TICK_DIV` cycles. A broken firing decision or a lost reload appears on `irq_pulse` one cycle after the firing cycle. A prescaler phase error first becomes visible as a counter step on the wrong cycle, at most `TICK_DIV` cycles after the fault.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned REG_W  = 2 * HALF_W;

  typedef logic [HALF_W-1:0] half_t;

  // step the count down, but never below zero
  function automatic half_t sat_dec(input half_t v);
    return (v == '0) ? v : half_t'(v - 1'b1);
  endfunction

  // next count: a software write first, then a reload, then a tick
  function automatic half_t next_count(input half_t cur, input half_t ival,
                                       input logic sw_wr, input half_t sw_val,
                                       input logic fire, input logic tick);
    if (sw_wr)     return sw_val;
    else if (fire) return ival;
    else if (tick) return sat_dec(cur);
    else           return cur;
  endfunction
endpackage

// File: rtl/thr_prescaler.sv
module thr_prescaler #(
  parameter int unsigned DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
      end
      assign tick = (phase == LAST);
    end
  endgenerate
endmodule

// File: rtl/thr_cause_filter.sv
module thr_cause_filter #(
  parameter int unsigned NCAUSE = 16
) (
  input  logic [NCAUSE-1:0] pend,
  input  logic [NCAUSE-1:0] sel,
  output logic [NCAUSE-1:0] pend_sel,
  output logic              any_sel
);
  assign pend_sel = pend & sel;
  assign any_sel  = |pend_sel;
endmodule

// File: rtl/thr_counter.sv
module thr_counter
  import thr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  fire,
  input  logic  wr_lo,
  input  logic  wr_hi,
  input  half_t wr_ival,
  input  half_t wr_cnt,
  output half_t ival,
  output half_t cnt,
  output logic  cnt_zero
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ival <= '0;
      cnt  <= '0;
    end else begin
      if (wr_lo) ival <= wr_ival;
      cnt <= next_count(cnt, ival, wr_hi, wr_cnt, fire, tick);
    end
  end
  assign cnt_zero = (cnt == '0);
endmodule

// File: rtl/irq_throttle_timer.sv
module irq_throttle_timer
  import thr_pkg::*;
#(
  parameter int unsigned NCAUSE   = 16,
  parameter int unsigned TICK_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] cause_pend,
  input  logic [NCAUSE-1:0] cause_sel,
  input  logic              reg_wr_lo,
  input  logic              reg_wr_hi,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              irq_pulse
);
  logic              tick;
  logic [NCAUSE-1:0] pend_sel;
  logic              any_sel;
  logic              cnt_zero;
  logic              fire;
  half_t             ival;
  half_t             cnt;
  logic              irq_q;

  thr_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  thr_cause_filter #(.NCAUSE(NCAUSE)) u_filt (
    .pend    (cause_pend),
    .sel     (cause_sel),
    .pend_sel(pend_sel),
    .any_sel (any_sel)
  );

  assign fire = cnt_zero & any_sel;

  thr_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .fire    (fire),
    .wr_lo   (reg_wr_lo),
    .wr_hi   (reg_wr_hi),
    .wr_ival (reg_wr_data[HALF_W-1:0]),
    .wr_cnt  (reg_wr_data[REG_W-1:HALF_W]),
    .ival    (ival),
    .cnt     (cnt),
    .cnt_zero(cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire;
  end

  assign irq_pulse   = irq_q;
  assign reg_rd_data = {cnt, ival};
endmodule

// File: rtl/irq_throttle_chk.sv
module irq_throttle_chk
  import thr_pkg::*;
#(
  parameter int unsigned NCAUSE = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic              tick,
  input logic              irq_pulse,
  input logic              wr_hi,
  input half_t             wr_cnt,
  input half_t             ival,
  input half_t             cnt,
  input logic [NCAUSE-1:0] pend_sel
);
  // R6
  fire_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq_pulse);
  // R6
  quiet_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !irq_pulse);
  // R7
  unselected_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_sel == '0) |-> !fire);
  // R4
  reload_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_hi) |=> (cnt == $past(ival)));
  // R8
  sw_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt == $past(wr_cnt)));
  // R5
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !fire && !tick) |=> $stable(cnt));
  // R5
  zero_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !wr_hi && !fire) |=> (cnt == '0));
  // R5
  tick_decrements_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !wr_hi && !fire) |=> (cnt == half_t'($past(cnt) - 1'b1)));
endmodule

bind irq_throttle_timer irq_throttle_chk #(.NCAUSE(NCAUSE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fire     (fire),
  .tick     (tick),
  .irq_pulse(irq_pulse),
  .wr_hi    (reg_wr_hi),
  .wr_cnt   (reg_wr_data[31:16]),
  .ival     (ival),
  .cnt      (cnt),
  .pend_sel (pend_sel)
);

// File: tb/irq_throttle_timer_test.sv
module irq_throttle_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC  = 16;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] cause_pend = '0;
  logic [NC-1:0] cause_sel = '0;
  logic          reg_wr_lo = 1'b0;
  logic          reg_wr_hi = 1'b0;
  logic [31:0]   reg_wr_data = '0;
  logic [31:0]   reg_rd_data;
  logic          irq_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // reference state
  int ival_m, cnt_m, pre_m;
  bit irq_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_throttle_timer #(.NCAUSE(NC), .TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .cause_pend(cause_pend), .cause_sel(cause_sel),
    .reg_wr_lo(reg_wr_lo), .reg_wr_hi(reg_wr_hi), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .irq_pulse(irq_pulse)
  );

  task automatic compare();
    logic [31:0] exp_rd;
    exp_rd = {cnt_m[15:0], ival_m[15:0]};
    n_cmp++;
    if (irq_pulse !== irq_m || reg_rd_data !== exp_rd) begin
      n_bad++;
      $display("FAIL %s t=%0t irq=%b exp %b rd=%h exp %h",
               cur_req, $time, irq_pulse, irq_m, reg_rd_data, exp_rd);
    end
  endtask

  // called at a falling edge: check, drive, advance the model
  task automatic step(input logic [NC-1:0] p, input logic [NC-1:0] s,
                      input bit wlo, input bit whi, input logic [31:0] wd);
    bit fire, tick;
    int new_cnt;
    compare();
    cause_pend = p; cause_sel = s;
    reg_wr_lo = wlo; reg_wr_hi = whi; reg_wr_data = wd;
    fire = (cnt_m == 0) && ((p & s) != 0);
    tick = (pre_m == DIV - 1);
    pre_m = tick ? 0 : pre_m + 1;
    if (whi)                     new_cnt = int'(wd[31:16]);
    else if (fire)               new_cnt = ival_m;
    else if (tick && cnt_m > 0)  new_cnt = cnt_m - 1;
    else                         new_cnt = cnt_m;
    if (wlo) ival_m = int'(wd[15:0]);
    cnt_m = new_cnt;
    irq_m = fire;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, 0, 0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    ival_m = 0; cnt_m = 0; pre_m = 0; irq_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1"; idle(3);
    // R9: first selected cause fires at once
    cur_req = "R9"; step(16'h0004, 16'h0004, 0, 0, '0); idle(2);
    // R3: zero interval, pulse on every pending cycle
    cur_req = "R3";
    for (int i = 0; i < 6; i++) step(16'h0101, 16'h0100, 0, 0, '0);
    idle(2);
    // R2: halves written separately and read back
    cur_req = "R2";
    step('0, '0, 1, 0, 32'hBEEF_0005);
    step('0, '0, 0, 1, 32'h0012_7777);
    idle(2);
    // R5: count down to zero and hold
    cur_req = "R5"; idle(90);
    // R8: write coinciding with a firing cycle wins over the reload
    cur_req = "R8";
    step(16'h0002, 16'h0002, 0, 1, 32'h0007_0000);
    idle(3);
    step('0, '0, 0, 1, 32'h0000_0000);
    step(16'h0002, 16'h0002, 0, 1, 32'h0009_0000);
    idle(2);
    step('0, '0, 0, 1, 32'h0000_0000);
    // R4 / R6: constant pending with interval 3 gives spaced pulses
    cur_req = "R4"; step('0, '0, 1, 0, 32'h0000_0003);
    cur_req = "R6";
    for (int i = 0; i < 60; i++) step(16'h8000, 16'hFFFF, 0, 0, '0);
    idle(20);
    // R7: unselected causes are ignored
    cur_req = "R7";
    for (int i = 0; i < 30; i++) step(16'h00F0, 16'hFF0F, 0, 0, '0);
    // mixed random traffic
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] wd;
      wd = {16'($urandom % 24), 16'($urandom % 6)};
      step(NC'($urandom), NC'($urandom), ($urandom % 40) == 0,
           ($urandom % 50) == 0, wd);
    end
    compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule